// File: doc/BRIEF.md
# Register-Mapped Serial Transmitter with Interrupt Flags

This block is an asynchronous serial transmitter that software drives through six byte-wide registers. There is a status register, a control register, a format register, two halves of a baud divisor, and a data register. A byte written to the data register goes into a one-byte holding buffer. It moves into a shift register as soon as that register is free. The line then carries a start bit, 5 to 9 data bits sent LSB first, an optional parity bit and one or two stop bits.

Two flags report progress, and each can raise an interrupt request. The buffer-empty flag means a new byte may be written. The transmit-done flag means the line has gone quiet with nothing left to send. The bit time comes from a programmable divisor with a normal and a double-speed mode.

Register addresses (`addr`): 0 status, 1 control, 2 format, 3 divisor low, 4 divisor high, 5 data.

Top module: `uart_tx_mapped`

## Requirements
- R1: After reset, `txd` is 1, both interrupt requests are 0 and the status register reads 0x20 (buffer-empty flag in bit 5 set, transmit-done flag in bit 6 clear).
- R2: Every bit on the line lasts exactly 16×(DIV+1) clock cycles, or 8×(DIV+1) cycles while status bit 1 (double speed) is 1.
- R3: DIV is the 16-bit value {divisor high register, divisor low register}.
- R4: The size code is {control bit 2, format bit 2, format bit 1}. Codes 0 to 3 give 5, 6, 7 and 8 data bits, and codes 4 to 7 give 9 data bits. The ninth data bit is taken from control bit 0.
- R5: A frame is a 0 start bit, then the data bits LSB first, then parity (if enabled), then the stop bits at 1. The line rests at 1 between frames.
- R6: Format bits 5:4 choose parity: 00 and 01 give no parity bit, 10 gives even parity and 11 gives odd parity, computed over all data bits including the ninth.
- R7: Format bit 3 = 1 sends two stop bits, and 0 sends one.
- R8: The buffer-empty flag clears on an accepted data write. It sets again in the cycle the byte moves into the shift register, which is the cycle after the write if the line is idle. It also sets when control bit 3 (transmit enable) goes from 0 to 1.
- R9: A data write while control bit 3 is 0 is dropped: no frame is sent and the buffer-empty flag does not change.
- R10: The transmit-done flag sets at the end of the last stop bit only if no byte is waiting. A waiting byte starts its start bit at that same clock edge, leaving no idle gap.
- R11: The transmit-done flag clears on a pulse of `ack_txc` or on a status write with bit 6 = 1. A status write with bit 6 = 0 leaves it set.
- R12: `irq_udre` is the buffer-empty flag ANDed with control bit 5, and `irq_txc` is the transmit-done flag ANDed with control bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ack_txc | input | 1 | Transmit-done interrupt acknowledge |
| txd | output | 1 | Serial line output |
| irq_udre | output | 1 | Buffer-empty interrupt request |
| irq_txc | output | 1 | Transmit-done interrupt request |

## Verification
The bench samples the line at the centre of every bit. It compares frames bit for bit, so a wrong parity sense, a swapped stop-bit count or a reserved size code that is not widened to nine bits all show up as a mismatched bit or a wrong frame length. Low runs are measured to the exact cycle. A divisor off by one, the halves swapped, or double speed ignored would change that count.

Two back-to-back bytes must appear as one unbroken bit stream. A design that set the transmit-done flag between them, or left a gap, fails this test. The bench also looks for three further faults:
- a byte written while disabled leaking onto the line later;
- a status write with bit 6 = 0 clearing the transmit-done flag;
- a re-enable of the transmitter that leaves the buffer-empty flag clear.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int MAX_DATA  = 9;
    localparam int FRAME_MAX = 1 + MAX_DATA + 1 + 2;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);

    // status bits
    localparam int ST_TXC  = 6;
    localparam int ST_UDRE = 5;
    localparam int ST_DBL  = 1;
    localparam int ST_MPM  = 0;
    // control bits
    localparam int CB_TXCIE = 6;
    localparam int CB_UDRIE = 5;
    localparam int CB_TXEN  = 3;
    localparam int CB_SZ2   = 2;
    localparam int CB_TX9   = 0;
    // format bits
    localparam int FC_PAR_LO = 4;
    localparam int FC_STOP   = 3;
    localparam int FC_SZ_LO  = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT = 3'd0,
        A_CTRL = 3'd1,
        A_FMT  = 3'd2,
        A_DIVL = 3'd3,
        A_DIVH = 3'd4,
        A_DATA = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_RSVD = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic [3:0] nbits;
        par_mode_e  par;
        logic       stop2;
        logic       bit9;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [LEN_W-1:0]     len;
    } frame_t;

    function automatic logic [3:0] size_bits(input logic [2:0] code);
        return (code < 3'd4) ? (4'd5 + {1'b0, code}) : 4'd9;
    endfunction

    function automatic fmt_t decode_fmt(input logic sz2, input logic [1:0] sz10,
                                        input logic [1:0] par, input logic stop2,
                                        input logic tx9);
        fmt_t f;
        f.nbits = size_bits({sz2, sz10});
        f.par   = par_mode_e'(par);
        f.stop2 = stop2;
        f.bit9  = tx9;
        return f;
    endfunction

    // bit 0 goes out first; unused upper positions stay 1 (stop/idle)
    function automatic frame_t build_frame(input logic [BYTE_W-1:0] d, input fmt_t f);
        frame_t           fr;
        logic             p;
        logic             b;
        logic [LEN_W-1:0] pos;
        fr.bits    = '1;
        fr.bits[0] = 1'b0;
        p   = 1'b0;
        pos = LEN_W'(1);
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < int'(f.nbits)) begin
                b = (i < BYTE_W) ? d[3'(i)] : f.bit9;
                fr.bits[pos] = b;
                p   = p ^ b;
                pos = pos + 1'b1;
            end
        end
        if (f.par == PAR_EVEN || f.par == PAR_ODD) begin
            fr.bits[pos] = (f.par == PAR_ODD) ? ~p : p;
            pos = pos + 1'b1;
        end
        fr.len = pos + LEN_W'(f.stop2 ? 2 : 1);
        return fr;
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OS_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             dbl,
    input  logic [DIV_W-1:0] div,
    output logic             bit_end
);
    localparam logic [OS_W-1:0] OS_NORM = OS_W'(15);
    localparam logic [OS_W-1:0] OS_FAST = OS_W'(7);

    logic [DIV_W-1:0] presc;
    logic [OS_W-1:0]  os;
    logic [OS_W-1:0]  os_last;
    logic             presc_wrap;

    assign os_last    = dbl ? OS_FAST : OS_NORM;
    assign presc_wrap = (presc == div);
    assign bit_end    = run && presc_wrap && (os >= os_last);

    // counters restart with every frame so each bit is a whole period
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            presc <= '0;
            os    <= '0;
        end else if (presc_wrap) begin
            presc <= '0;
            os    <= (os >= os_last) ? '0 : os + 1'b1;
        end else begin
            presc <= presc + 1'b1;
        end
    end

    a_r2_idle_reset: assert property (@(posedge clk) disable iff (rst)
        !run |=> (presc == '0 && os == '0));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame_in,
    input  logic   bit_end,
    output logic   busy,
    output logic   done,
    output logic   txd
);
    logic [FRAME_MAX-1:0] shreg;
    logic [LEN_W-1:0]     remain;

    assign done = busy && bit_end && (remain == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            txd    <= 1'b1;
            shreg  <= '1;
            remain <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            txd    <= frame_in.bits[0];
            shreg  <= {1'b1, frame_in.bits[FRAME_MAX-1:1]};
            remain <= frame_in.len;
        end else if (busy && bit_end) begin
            if (remain == LEN_W'(1)) begin
                busy <= 1'b0;
                txd  <= 1'b1;
            end else begin
                txd    <= shreg[0];
                shreg  <= {1'b1, shreg[FRAME_MAX-1:1]};
                remain <= remain - 1'b1;
            end
        end
    end

    a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);
    a_r5_start_after_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (busy && !txd));

endmodule

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              ack_txc,
    input  logic              busy,
    input  logic              done,
    output logic              load,
    output frame_t            frame,
    output logic [DIV_W-1:0]  div,
    output logic              dbl,
    output logic              irq_udre,
    output logic              irq_txc
);
    logic [BYTE_W-1:0] ctrl, fmtr, div_lo, div_hi, hold;
    logic              dbl_q, mpm_q, udre, txc, hold_full;
    logic              txen, wr_stat, wr_ctrl, wr_data, txen_rise, txc_set, txc_clr;
    fmt_t              fmt;

    assign txen      = ctrl[CB_TXEN];
    assign wr_stat   = wr_en && (addr == A_STAT);
    assign wr_ctrl   = wr_en && (addr == A_CTRL);
    assign wr_data   = wr_en && (addr == A_DATA) && txen;
    assign txen_rise = wr_ctrl && wdata[CB_TXEN] && !txen;
    assign load      = hold_full && txen && (!busy || done);
    assign txc_set   = done && !load;
    assign txc_clr   = ack_txc || (wr_stat && wdata[ST_TXC]);

    assign fmt   = decode_fmt(ctrl[CB_SZ2], fmtr[FC_SZ_LO+1:FC_SZ_LO],
                              fmtr[FC_PAR_LO+1:FC_PAR_LO], fmtr[FC_STOP], ctrl[CB_TX9]);
    assign frame = build_frame(hold, fmt);
    assign div   = DIV_W'({div_hi, div_lo});
    assign dbl   = dbl_q;

    assign irq_udre = udre && ctrl[CB_UDRIE];
    assign irq_txc  = txc && ctrl[CB_TXCIE];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            fmtr   <= '0;
            div_lo <= '0;
            div_hi <= '0;
            dbl_q  <= 1'b0;
            mpm_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (addr)
                A_STAT: begin
                    dbl_q <= wdata[ST_DBL];
                    mpm_q <= wdata[ST_MPM];
                end
                A_CTRL:  ctrl   <= wdata;
                A_FMT:   fmtr   <= wdata;
                A_DIVL:  div_lo <= wdata;
                A_DIVH:  div_hi <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold      <= '0;
            hold_full <= 1'b0;
        end else if (wr_data) begin
            hold      <= wdata;
            hold_full <= 1'b1;
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            udre <= 1'b1;
        end else if (wr_data) begin
            udre <= 1'b0;
        end else if (load || txen_rise) begin
            udre <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txc <= 1'b0;
        end else if (txc_set) begin
            txc <= 1'b1;
        end else if (txc_clr) begin
            txc <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_STAT: begin
                rdata[ST_TXC]  = txc;
                rdata[ST_UDRE] = udre;
                rdata[ST_DBL]  = dbl_q;
                rdata[ST_MPM]  = mpm_q;
            end
            A_CTRL:  rdata = {ctrl[7:2], 1'b0, ctrl[0]};
            A_FMT:   rdata = fmtr;
            A_DIVL:  rdata = div_lo;
            A_DIVH:  rdata = div_hi;
            default: rdata = '0;
        endcase
    end

    a_r8_write_clears_udre: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> !udre);
    a_r9_drop_keeps_udre: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_DATA && !txen) |=> $stable(udre));
    a_r11_ack_clears_txc: assert property (@(posedge clk) disable iff (rst)
        (ack_txc && !txc_set) |=> !txc);
    a_r10_txc_when_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(txc) |-> (!busy && !hold_full));

endmodule

// File: rtl/uart_tx_mapped.sv
module uart_tx_mapped
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic        ack_txc,
    output logic        txd,
    output logic        irq_udre,
    output logic        irq_txc
);
    logic             load, busy, done, bit_end, dbl;
    logic [DIV_W-1:0] div;
    frame_t           frame;

    uart_tx_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ack_txc(ack_txc), .busy(busy), .done(done),
        .load(load), .frame(frame), .div(div), .dbl(dbl),
        .irq_udre(irq_udre), .irq_txc(irq_txc)
    );

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .run(busy), .dbl(dbl), .div(div), .bit_end(bit_end)
    );

    uart_tx_shifter u_shift (
        .clk(clk), .rst(rst), .load(load), .frame_in(frame), .bit_end(bit_end),
        .busy(busy), .done(done), .txd(txd)
    );

endmodule

// File: tb/tb_uart_tx_mapped.sv
module tb_uart_tx_mapped;
    import uart_tx_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ack_txc = 1'b0;
    logic       txd, irq_udre, irq_txc;

    int errors = 0;
    int total  = 0;
    int P      = 32;   // DIV=1, normal speed

    always #4 clk = ~clk;

    uart_tx_mapped dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ack_txc(ack_txc), .txd(txd),
        .irq_udre(irq_udre), .irq_txc(irq_txc)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack_txc = 1'b1;
        @(negedge clk); ack_txc = 1'b0;
    endtask

    task automatic cap(input int n, output logic [31:0] v);
        int cur;
        v = '0;
        while (txd !== 1'b0) @(negedge clk);
        cur = 0;
        for (int k = 0; k < n; k++) begin
            repeat (k*P + P/2 - cur) @(negedge clk);
            cur = k*P + P/2;
            v[k] = txd;
        end
    endtask

    task automatic low_run(output int n);
        n = 0;
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0) begin @(negedge clk); n++; end
    endtask

    task automatic model(input logic [7:0] d, input logic b9, input int nb,
                         input logic [1:0] par, input logic two,
                         output logic [31:0] v, output int len);
        logic p;
        int   pos;
        v = '1; v[0] = 1'b0; p = 1'b0; pos = 1;
        for (int i = 0; i < nb; i++) begin
            v[pos] = (i == 8) ? b9 : d[i];
            p ^= v[pos];
            pos++;
        end
        if (par[1]) begin v[pos] = par[0] ? ~p : p; pos++; end
        len = pos + (two ? 2 : 1);
    endtask

    task automatic send_case(input string req, input logic [7:0] d, input logic [2:0] code,
                             input logic tx9, input logic [1:0] par, input logic two);
        logic [31:0] got, exp, mask;
        logic [7:0]  s;
        int          len, nb;
        nb = (code < 4) ? int'(code) + 5 : 9;
        model(d, tx9, nb, par, two, exp, len);
        mask = (32'd1 << len) - 1;
        wr(A_FMT, {2'b00, par, two, code[1:0], 1'b0});
        wr(A_CTRL, {4'b0000, 1'b1, code[2], 1'b0, tx9});
        wr(A_DATA, d);
        cap(len, got);
        chk(req, "frame bits", got & mask, exp & mask);
        rd(A_STAT, s);
        chk("R10", "txc during stop", {31'd0, s[6]}, 32'd0);
        repeat (P/2 + 1) @(negedge clk);
        rd(A_STAT, s);
        chk("R10", "txc after frame", {31'd0, s[6]}, 32'd1);
        pulse_ack();
        rd(A_STAT, s);
        chk("R11", "txc after ack", {31'd0, s[6]}, 32'd0);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        rd(A_STAT, s);
        chk("R1", "status", {24'd0, s}, 32'h20);
        chk("R1", "txd", {31'd0, txd}, 32'd1);
        chk("R1", "irqs", {30'd0, irq_udre, irq_txc}, 32'd0);
    endtask

    task automatic t_basic();
        logic [7:0] s;
        wr(A_DIVL, 8'd1);
        wr(A_FMT, 8'h06);
        wr(A_CTRL, 8'h08);
        wr(A_DATA, 8'hA5);
        rd(A_STAT, s);
        chk("R8", "udre after write", {31'd0, s[5]}, 32'd0);
        @(negedge clk);
        rd(A_STAT, s);
        chk("R8", "udre after move", {31'd0, s[5]}, 32'd1);
        chk("R5", "start bit", {31'd0, txd}, 32'd0);
        repeat (12*P) @(negedge clk);
        pulse_ack();
    endtask

    task automatic t_formats();
        send_case("R5", 8'hA5, 3'd3, 1'b0, 2'b00, 1'b0);
        send_case("R4", 8'h5A, 3'd7, 1'b1, 2'b10, 1'b1);
        send_case("R6", 8'h4B, 3'd2, 1'b0, 2'b11, 1'b0);
        send_case("R4", 8'hC3, 3'd5, 1'b0, 2'b00, 1'b0);
        send_case("R6", 8'h03, 3'd3, 1'b0, 2'b01, 1'b0);
        send_case("R7", 8'h2D, 3'd1, 1'b0, 2'b10, 1'b1);
        send_case("R4", 8'h17, 3'd0, 1'b0, 2'b11, 1'b1);
    endtask

    task automatic t_period();
        int n;
        wr(A_FMT, 8'h00);
        wr(A_CTRL, 8'h08);
        wr(A_DATA, 8'h00);
        low_run(n);
        chk("R2", "normal low run", n, 6*16*2);
        repeat (2*P) @(negedge clk);
        wr(A_STAT, 8'h02);
        wr(A_DATA, 8'h00);
        low_run(n);
        chk("R2", "double low run", n, 6*8*2);
        repeat (2*P) @(negedge clk);
        wr(A_DIVL, 8'h00);
        wr(A_DIVH, 8'h01);
        wr(A_DATA, 8'h00);
        low_run(n);
        chk("R3", "split divisor low run", n, 6*8*257);
        repeat (2*8*257) @(negedge clk);
        wr(A_STAT, 8'h00);
        wr(A_DIVH, 8'h00);
        wr(A_DIVL, 8'h01);
        pulse_ack();
    endtask

    task automatic t_ignore();
        logic [7:0] s;
        int lows;
        wr(A_CTRL, 8'h00);
        wr(A_DATA, 8'h55);
        rd(A_STAT, s);
        chk("R9", "udre unchanged", {31'd0, s[5]}, 32'd1);
        lows = 0;
        for (int i = 0; i < 3*P; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
        wr(A_CTRL, 8'h08);
        for (int i = 0; i < 3*P; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
        chk("R9", "line stayed idle", lows, 0);
        rd(A_STAT, s);
        chk("R9", "no txc", {31'd0, s[6]}, 32'd0);
    endtask

    task automatic t_b2b();
        logic [31:0] got, ea, eb;
        logic [7:0]  s;
        int la, lb;
        wr(A_FMT, 8'h06);
        wr(A_CTRL, 8'h08);
        model(8'h3C, 1'b0, 8, 2'b00, 1'b0, ea, la);
        model(8'hE1, 1'b0, 8, 2'b00, 1'b0, eb, lb);
        wr(A_DATA, 8'h3C);
        @(negedge clk);
        wr(A_DATA, 8'hE1);
        cap(la + lb, got);
        chk("R10", "back-to-back stream", got & 32'hFFFFF, ((eb << la) | (ea & 32'h3FF)) & 32'hFFFFF);
        rd(A_STAT, s);
        chk("R10", "txc before end", {31'd0, s[6]}, 32'd0);
        repeat (P/2 + 1) @(negedge clk);
        rd(A_STAT, s);
        chk("R10", "txc at end", {31'd0, s[6]}, 32'd1);
        wr(A_CTRL, 8'h68);
        chk("R12", "irq lines", {30'd0, irq_udre, irq_txc}, 32'd3);
        wr(A_STAT, 8'h00);
        rd(A_STAT, s);
        chk("R11", "write 0 keeps txc", {31'd0, s[6]}, 32'd1);
        wr(A_STAT, 8'h40);
        rd(A_STAT, s);
        chk("R11", "write 1 clears txc", {31'd0, s[6]}, 32'd0);
        chk("R12", "irq_txc after clear", {31'd0, irq_txc}, 32'd0);
        wr(A_CTRL, 8'h08);
        chk("R12", "irq_udre masked", {31'd0, irq_udre}, 32'd0);
    endtask

    task automatic t_txen_rise();
        logic [7:0] s;
        wr(A_DATA, 8'h11);
        @(negedge clk);
        wr(A_DATA, 8'h22);
        rd(A_STAT, s);
        chk("R8", "udre with byte waiting", {31'd0, s[5]}, 32'd0);
        wr(A_CTRL, 8'h00);
        rd(A_STAT, s);
        chk("R8", "udre after disable", {31'd0, s[5]}, 32'd0);
        wr(A_CTRL, 8'h08);
        rd(A_STAT, s);
        chk("R8", "udre on enable rise", {31'd0, s[5]}, 32'd1);
        repeat (22*P) @(negedge clk);
        pulse_ack();
        chk("R5", "idle after frames", {31'd0, txd}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_formats();
        t_period();
        t_ignore();
        t_b2b();
        t_txen_rise();
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

endmodule